// File: doc/BRIEF.md
# Auto-MDIX Link Hunting Controller

This controller brings an Ethernet port up without knowing in advance whether the cable is straight or crossed. After a start pulse it polls a PHY status register until receive energy is reported. It then drives its crossover-select output to the straight setting and starts a timed link search. Each poll of the PHY basic status register that finds no link flips the select between straight (MDI, 0) and crossed (MDIX, 1). The search ends when link is reported or when the poll budget runs out.

All PHY traffic goes through a register-style management access port. The controller presents a 32-bit command word together with a one-cycle issue strobe. It then watches a 32-bit status word until the busy flag clears, and takes the returned register value from the low half. The poll budgets and the wait between link polls, counted in clock cycles, are parameters. The defaults are 99 reads per phase and 300 ms at 50 MHz.

Top module: `mdix_hunter`

## Requirements
- R1: Out of reset the controller is idle: `acc_issue`, `xover_sel`, `done`, `fail` and `mode_mdix` are all 0, and nothing is issued until `start` is seen.
- R2: Each access is a single-cycle `acc_issue` pulse with a command word of bit 31 = 1 (start), bit 30 = 0 (read), PHY address 6 in bits 25:21 and the register number in bits 20:16.
- R3: After an issue the controller treats the access as complete only on a cycle where `acc_stat` bit 31 is 0, and only then uses `acc_stat[15:0]` as the register value. Values shown while bit 31 is 1 are ignored.
- R4: Phase one reads register 17. Bit 1 of the value set means signal present. When a read finds no signal, the next read is issued on the cycle after the controller samples the completion. After SIG_POLLS reads with no signal, `fail` is set.
- R5: When a signal is found, `xover_sel` is driven to 0 (MDI) before the first link poll. If phase one fails, `xover_sel` keeps the value it had before the start.
- R6: Phase two reads register 1. Each such issue comes WAIT_CYCLES clock edges after the edge at which the controller samples the completion of the previous access, whether that access was the signal read or a link read.
- R7: A phase-two read with bit 2 set sets `done` and copies the current `xover_sel` into `mode_mdix`. `xover_sel` and `mode_mdix` then hold until the next start.
- R8: Every phase-two read without link toggles `xover_sel`, the last one included. After LINK_POLLS such reads, `fail` is set.
- R9: `done` and `fail` are never both 1, stay set until the next `start`, and are both cleared by `start`. `start` restarts the sequence at phase one. `mode_mdix` changes only on success.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin (or restart) the search |
| acc_cmd | output | 32 | Management access command word |
| acc_issue | output | 1 | One-cycle strobe: acc_cmd is a new request |
| acc_stat | input | 32 | Access status: bit 31 busy, bits 15:0 read data |
| xover_sel | output | 1 | Crossover select, 0 = MDI, 1 = MDIX |
| done | output | 1 | Link found (sticky) |
| fail | output | 1 | A poll budget ran out (sticky) |
| mode_mdix | output | 1 | Select setting under which link was found |

## Verification
The hardest outcomes to reach are those that depend on the order of events across both phases. These include a link that only appears under one select polarity after several polls, a signal found on the very last allowed read, and a phase-one failure that follows an earlier phase-two failure, so that the carried-over select value is visible. The bench models the PHY behind the access port. It answers with noise bits while busy and with a configurable latency. For every start it chooses the read at which signal appears, the read at which link may appear and the polarity link needs. It sweeps all of these over small budgets and predicts the result with a short loop.

// File: rtl/mdix_hunter.sv
module mdix_hunter #(
  parameter int PHY_ADDR    = 6,
  parameter int SIG_REG     = 17,
  parameter int LINK_REG    = 1,
  parameter int SIG_BIT     = 1,
  parameter int LINK_BIT    = 2,
  parameter int SIG_POLLS   = 99,
  parameter int LINK_POLLS  = 99,
  parameter int WAIT_CYCLES = 15_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic [31:0] acc_cmd,
  output logic        acc_issue,
  input  logic [31:0] acc_stat,
  output logic        xover_sel,
  output logic        done,
  output logic        fail,
  output logic        mode_mdix
);

  localparam int MAXP = (SIG_POLLS > LINK_POLLS) ? SIG_POLLS : LINK_POLLS;
  localparam int PW   = $clog2(MAXP + 1);
  localparam int DW   = $clog2(WAIT_CYCLES + 1);
  localparam logic [4:0] PA  = 5'(PHY_ADDR);
  localparam logic [4:0] SRA = 5'(SIG_REG);
  localparam logic [4:0] LRA = 5'(LINK_REG);

  typedef enum logic [2:0] {IDLE, SIG_REQ, SIG_WAIT, LNK_DLY, LNK_REQ, LNK_WAIT} state_t;

  state_t          st;
  logic [PW-1:0]   polls;
  logic [DW-1:0]   dly;
  logic            free;
  logic            unused_stat;

  assign free        = !acc_stat[31];
  assign unused_stat = ^acc_stat[30:0];
  assign acc_issue   = (st == SIG_REQ) || (st == LNK_REQ);
  assign acc_cmd     = {2'b10, 4'b0000, PA, (st == LNK_REQ) ? LRA : SRA, 16'h0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      polls     <= '0;
      dly       <= '0;
      xover_sel <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      mode_mdix <= 1'b0;
    end else if (start) begin
      st    <= SIG_REQ;
      polls <= '0;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      case (st)
        SIG_REQ: begin
          polls <= polls + 1'b1;
          st    <= SIG_WAIT;
        end
        SIG_WAIT: if (free) begin
          if (acc_stat[SIG_BIT]) begin
            xover_sel <= 1'b0;
            polls     <= '0;
            dly       <= '0;
            st        <= LNK_DLY;
          end else if (polls == PW'(SIG_POLLS)) begin
            fail <= 1'b1;
            st   <= IDLE;
          end else begin
            st <= SIG_REQ;
          end
        end
        LNK_DLY: begin
          if (dly == DW'(WAIT_CYCLES - 1)) st <= LNK_REQ;
          else                              dly <= dly + 1'b1;
        end
        LNK_REQ: begin
          polls <= polls + 1'b1;
          st    <= LNK_WAIT;
        end
        LNK_WAIT: if (free) begin
          if (acc_stat[LINK_BIT]) begin
            done      <= 1'b1;
            mode_mdix <= xover_sel;
            st        <= IDLE;
          end else begin
            xover_sel <= !xover_sel;
            if (polls == PW'(LINK_POLLS)) begin
              fail <= 1'b1;
              st   <= IDLE;
            end else begin
              dly <= '0;
              st  <= LNK_DLY;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdix_hunter_chk.sv
module mdix_hunter_chk #(
  parameter int LINK_BIT = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        acc_issue,
  input logic [31:0] acc_stat,
  input logic        xover_sel,
  input logic        done,
  input logic        fail
);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !start |=> fail);

  a_r2_issue_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    acc_issue && !start |=> !acc_issue);

  // R3 / R8: the select only moves right after a completed access is taken
  a_r8_xover_moves_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (xover_sel != $past(xover_sel)) |-> $past(!acc_stat[31] && !acc_issue));

  a_r7_done_on_link: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!acc_stat[31] && acc_stat[LINK_BIT]));

endmodule

bind mdix_hunter mdix_hunter_chk #(.LINK_BIT(LINK_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .acc_issue(acc_issue),
  .acc_stat(acc_stat), .xover_sel(xover_sel), .done(done), .fail(fail)
);

// File: tb/mdix_hunter_test.sv
`timescale 1ns/1ps
module mdix_hunter_test;
  localparam int SP = 4, LP = 5, WC = 3;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] acc_cmd, acc_stat;
  logic acc_issue, xover_sel, done, fail, mode_mdix;

  int checks = 0, errors = 0;
  int sig_at, link_at, want, lat;
  int sig_reads, link_reads, field_err, gap_err, lat_cnt, nc, t_free;
  logic busy, first;
  logic [15:0] reply;

  always #10 clk = ~clk;

  mdix_hunter #(.SIG_POLLS(SP), .LINK_POLLS(LP), .WAIT_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_cmd(acc_cmd), .acc_issue(acc_issue),
    .acc_stat(acc_stat), .xover_sel(xover_sel), .done(done), .fail(fail), .mode_mdix(mode_mdix));

  // PHY model behind the access port
  initial begin
    busy = 0; acc_stat = 32'h0000_FFFF; nc = 0; t_free = 0; first = 1;
    forever begin
      @(negedge clk);
      nc++;
      if (busy) begin
        if (lat_cnt == 0) begin busy = 0; acc_stat = {16'h0000, reply}; t_free = nc; end
        else lat_cnt--;
      end else if (acc_issue) begin
        if (acc_cmd[31:30] != 2'b10 || acc_cmd[25:21] != 5'd6) field_err++;
        if (acc_cmd[20:16] == 5'd17) begin
          if (link_reads > 0) field_err++;
          if (!first && nc - t_free != 1) gap_err++;
          reply = (sig_reads >= sig_at) ? 16'h0002 : 16'hFFFD;
          sig_reads++;
        end else if (acc_cmd[20:16] == 5'd1) begin
          if (nc - t_free != WC + 1) gap_err++;
          reply = (link_reads >= link_at && int'(xover_sel) == want) ? 16'h0004 : 16'hFFFB;
          link_reads++;
        end else field_err++;
        first = 0;
        busy = 1; lat_cnt = lat;
        acc_stat = 32'hFFFF_FFFF;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual %0d expected %0d", req, act, exp); end
  endtask

  logic exp_x = 0, exp_mode = 0;

  task automatic run(input int s, input int l, input int w, input int lt);
    bit exp_done; int exp_sr, exp_lr, n;
    sig_at = s; link_at = l; want = w; lat = lt;
    sig_reads = 0; link_reads = 0; field_err = 0; gap_err = 0; first = 1;
    start = 1; @(negedge clk); start = 0;
    chk(!done && !fail, "R9 start clears", int'({done, fail}), 0);
    n = 0;
    while (!done && !fail && n < 2000) begin @(negedge clk); n++; end
    exp_done = 0; exp_lr = 0;
    if (s >= SP) exp_sr = SP;
    else begin
      exp_sr = s + 1; exp_x = 0; exp_lr = LP;
      for (int i = 0; i < LP; i++)
        if (i >= l && i % 2 == w) begin exp_done = 1; exp_lr = i + 1; break; end
      if (exp_done) begin exp_x = w[0]; exp_mode = w[0]; end
      else exp_x = LP[0];
    end
    repeat (3) @(negedge clk);
    chk(done == exp_done && fail == !exp_done, exp_done ? "R7 done" : "R8 fail",
        int'({done, fail}), exp_done ? 2 : 1);
    chk(sig_reads == exp_sr, "R4 signal reads", sig_reads, exp_sr);
    chk(link_reads == exp_lr, "R8 link reads", link_reads, exp_lr);
    chk(xover_sel == exp_x, "R5 select", int'(xover_sel), int'(exp_x));
    chk(mode_mdix == exp_mode, "R7 mode", int'(mode_mdix), int'(exp_mode));
    chk(field_err == 0, "R2 command fields", field_err, 0);
    chk(gap_err == 0, "R6 issue spacing", gap_err, 0);
    chk(!acc_issue, "R3 quiet after end", int'(acc_issue), 0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sig_at = 0; link_at = 0; want = 0; lat = 0;
    sig_reads = 0; link_reads = 0; field_err = 0; gap_err = 0;
    repeat (3) @(negedge clk);
    chk(!acc_issue && !xover_sel && !done && !fail && !mode_mdix, "R1 reset",
        int'({acc_issue, xover_sel, done, fail, mode_mdix}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!acc_issue && sig_reads == 0, "R1 idle until start", sig_reads, 0);
    for (int s = 0; s <= SP; s++)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l <= LP + 1; l++)
          run(s, l, w, (s + l + w) % 3);
    run(SP, 0, 0, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule